// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers up to seven interrupt events from a peripheral and presents them to a processor as one active-low request line. Each event source has a flag bit. A one-cycle pulse on the matching event input sets the flag, and the flag stays set until software clears it. Each flag also has an enable bit in the same position. The request line goes low only while at least one flag and its own enable bit are both set.

Software talks to the block over a minimal register bus with two registers, picked by a one-bit select. The flag register reads back the stored flags in bits 6..0. Its bit 7 is not storage: it shows live whether any enabled flag is pending. Writing a one to a flag position clears that flag. The enable register uses bit 7 of the written data as a direction bit: 1 sets the enables marked by ones in bits 6..0, and 0 clears them. No encoding of the source is done in hardware. Software reads the flags and tests them from the top bit down.

A parameter chooses how the request line is driven. It can be a plain combinational function of the flag and enable state, or it can come from a flop that follows that state one clock later.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags and all enables are 0, the flag register reads 0x00, the enable register reads 0x80 and `irq_n` is 1.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets flag i. The flag then stays set at later edges with no event input, as long as no clear is written to it.
- R3: A write with `reg_sel`=0 (flag register) clears every flag whose data bit (6..0) is 1. Flags whose data bit is 0 are unchanged. Data bit 7 of such a write has no effect.
- R4: If an event and a write-one clear reach the same flag at the same edge, the flag ends up set.
- R5: A write with `reg_sel`=1 (enable register) and data bit 7 = 1 sets every enable whose data bit (6..0) is 1. The other enables are unchanged.
- R6: A write with `reg_sel`=1 and data bit 7 = 0 clears every enable whose data bit (6..0) is 1. The other enables are unchanged. Enables change only on enable-register writes.
- R7: While `reg_sel`=1, `rd_data` is {1, enables[6:0]}.
- R8: While `reg_sel`=0, `rd_data` is {any, flags[6:0]}, where any is the OR over i of (flag[i] AND enable[i]).
- R9: `irq_n` is the inverse of that same OR. With `REG_IRQ`=1 it follows the flag and enable state with one clock of delay. With `REG_IRQ`=0 it has no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the selected register (combinational) |
| evt_pulse | input | NUM_SRC | Event pulses, one per flag |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with seven sources, an eight-bit bus and `REG_IRQ`=1. With the registered request line, a one-clock lag appears between a register change and the pin. A bench that samples at the wrong cycle would catch this lag, so the sample point for `irq_n` is placed one clock after the readback. With the full seven sources, bit 6 (the topmost flag) and the direction bit both take part. This lets the set-wins collision, a clear aimed only at the status bit 7, and a clear-all of the enables be tested against the true register edges.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic {
      SEL_FLAGS   = 1'b0,
      SEL_ENABLES = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_wr,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic [NUM_SRC-1:0] evt,
   output logic [NUM_SRC-1:0] flags
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic nxt;
      // an event on this edge overrides a clear on the same edge
      always_comb begin
         nxt = flags[i];
         if (clr_wr && clr_mask[i]) nxt = 1'b0;
         if (evt[i])                nxt = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= nxt;
      end
   end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd,
   input  logic               set_dir,
   input  logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] enables
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enables <= '0;
      else if (upd) begin
         if (set_dir) enables <= enables | mask;
         else         enables <= enables & ~mask;
      end
   end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_pend,
   output logic irq_n
);
   if (REG_IRQ) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~any_pend;
      end
   end else begin : g_comb
      assign irq_n = ~any_pend;
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int NUM_SRC = 7,
   parameter int DATA_W  = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_SRC-1:0]  evt_pulse,
   output logic                irq_n
);
   import irq_agg_pkg::*;

   localparam int CTRL_BIT = DATA_W - 1;

   if (NUM_SRC + 1 != DATA_W) begin : g_chk_width
      $error("irq_aggregator: DATA_W must equal NUM_SRC + 1");
   end
   if (NUM_SRC < 1) begin : g_chk_src
      $error("irq_aggregator: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] en_q;
   logic               any_pend;
   logic               wr_flags;
   logic               wr_enables;

   assign wr_flags   = wr_en && (reg_sel_e'(reg_sel) == SEL_FLAGS);
   assign wr_enables = wr_en && (reg_sel_e'(reg_sel) == SEL_ENABLES);

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_wr   (wr_flags),
      .clr_mask (wr_data[NUM_SRC-1:0]),
      .evt      (evt_pulse),
      .flags    (flag_q)
   );

   irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_enables (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (wr_enables),
      .set_dir (wr_data[CTRL_BIT]),
      .mask    (wr_data[NUM_SRC-1:0]),
      .enables (en_q)
   );

   assign any_pend = |(flag_q & en_q);

   irq_out_stage #(.REG_IRQ(REG_IRQ)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_pend (any_pend),
      .irq_n    (irq_n)
   );

   always_comb begin
      if (reg_sel_e'(reg_sel) == SEL_ENABLES) rd_data = {1'b1, en_q};
      else                                    rd_data = {any_pend, flag_q};
   end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int NUM_SRC = 7,
   parameter int DATA_W  = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_sel,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic [NUM_SRC-1:0] evt_pulse,
   input logic               irq_n,
   input logic [NUM_SRC-1:0] flag_q,
   input logic [NUM_SRC-1:0] en_q
);
   logic flag_wr, en_wr;
   assign flag_wr = wr_en && !reg_sel;
   assign en_wr   = wr_en && reg_sel;

   // event pulses are always captured, even against a clear (R2, R4)
   assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

   assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> ((flag_q & $past(wr_data[NUM_SRC-1:0] & ~evt_pulse)) == '0));

   assert_en_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_q));

   assert_en_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (rd_data == {1'b1, en_q}));

   if (REG_IRQ) begin : g_reg
      assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_n == !$past(|(flag_q & en_q))));
   end else begin : g_comb
      assert_irq_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_n == !(|(flag_q & en_q)));
   end
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
   .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
   .irq_n(irq_n), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
   localparam int NS = 7;
   localparam int DW = 8;
   localparam int NV = 12;
   // vector: {evt[6:0], wr, sel, wdata[7:0], rd_sel, exp_rd[7:0], exp_irq_n}
   localparam logic [26:0] VEC [NV] = '{
      {7'h05, 1'b0, 1'b0, 8'h00, 1'b0, 8'h05, 1'b1}, // R2 events on 0,2
      {7'h00, 1'b1, 1'b1, 8'h81, 1'b1, 8'h81, 1'b0}, // R5 set en0
      {7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h85, 1'b0}, // R8 status bit
      {7'h00, 1'b1, 1'b0, 8'h01, 1'b0, 8'h04, 1'b1}, // R3 clear flag0
      {7'h00, 1'b1, 1'b1, 8'h84, 1'b1, 8'h85, 1'b0}, // R5 set en2
      {7'h00, 1'b1, 1'b1, 8'h01, 1'b1, 8'h84, 1'b0}, // R6 clear en0
      {7'h40, 1'b1, 1'b0, 8'h04, 1'b0, 8'h40, 1'b1}, // R3 clear f2, event f6
      {7'h04, 1'b1, 1'b0, 8'h04, 1'b0, 8'hC4, 1'b0}, // R4 set beats clear
      {7'h00, 1'b1, 1'b0, 8'h80, 1'b0, 8'hC4, 1'b0}, // R3 bit7 ignored
      {7'h00, 1'b1, 1'b1, 8'h00, 1'b1, 8'h84, 1'b0}, // R6 empty mask
      {7'h00, 1'b1, 1'b1, 8'h7F, 1'b1, 8'h80, 1'b1}, // R7 clear all en
      {7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h44, 1'b1}  // R8 no enabled flags
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_sel = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [NS-1:0] evt_pulse = '0;
   logic          irq_n;
   int            n_run = 0;
   int            n_fail = 0;

   always #5 clk = ~clk;

   irq_aggregator #(.NUM_SRC(NS), .DATA_W(DW), .REG_IRQ(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
      .irq_n(irq_n)
   );

   function automatic string vec_tag(int i);
      case (i)
         0: return "R2";  1: return "R5";  2: return "R8";  3: return "R3";
         4: return "R5";  5: return "R6";  6: return "R3";  7: return "R4";
         8: return "R3";  9: return "R6"; 10: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      reg_sel = 1'b0; #1;
      check("R1", rd_data, 8'h00);
      check("R1", irq_n, 1'b1);
      reg_sel = 1'b1; #1;
      check("R1", rd_data, 8'h80);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         evt_pulse = VEC[i][26:20];
         wr_en     = VEC[i][19];
         reg_sel   = VEC[i][18];
         wr_data   = VEC[i][17:10];
         @(negedge clk);
         evt_pulse = '0;
         wr_en     = 1'b0;
         wr_data   = '0;
         reg_sel   = VEC[i][9];
         #1;
         check(vec_tag(i), rd_data, VEC[i][8:1]);
         @(negedge clk);
         check("R9", irq_n, VEC[i][0]);
      end

      // R9: registered line lags a new enabled flag by one clock
      @(negedge clk);
      reg_sel = 1'b1; wr_en = 1'b1; wr_data = 8'hC0; // set en6, flag6 pending
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check("R9", irq_n, 1'b1);
      @(negedge clk);
      check("R9", irq_n, 1'b0);

      // R1 reset in mid-run returns everything to idle
      rst_n = 1'b0; #1;
      reg_sel = 1'b0; #1;
      check("R1", rd_data, 8'h00);
      check("R1", irq_n, 1'b1);
      reg_sel = 1'b1; #1;
      check("R1", rd_data, 8'h80);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule